// File: doc/BRIEF.md
# UART FIFO Event Interrupt Controller

This block sits beside the FIFOs and serial logic of a UART and turns their single-cycle event strobes into sticky interrupt status bits. Each event type owns one bit of a 12-bit status vector. Hardware sets a bit when its event occurs. Software clears it by writing a one to that position. A mask register of the same width decides which recorded bits may raise the single interrupt line.

Two of the events are qualified against programmable thresholds. The receive almost-full event is tested only when a byte is being pushed into the receive FIFO. The transmit almost-empty event is tested only when a byte is being popped from the transmit FIFO. A steady FIFO level alone therefore never raises either bit.

The register port is a plain select/write/data interface. Select 0 is the status vector and select 1 is the mask. Read data is combinational and has no side effects.

Top module: `uart_evt_irq`

## Requirements
- R1: Each event sets its own status bit one cycle later. The bit positions are: 0 empty receive-data read, 1 write to a full write FIFO, 2 framing error, 3 parity error, 4 receive overflow, 5 receive almost-full, 7 transmit pop, 8 receive push, 9 write-FIFO pop, 10 illegal receive read in protocol mode, 11 transmit almost-empty.
- R2: Status bits are sticky. A write with select 0 clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A mask bit at 1 keeps its status bit from driving `irq`, but the status bit is still recorded. A mask write is select 1.
- R4: Bit 5 is set only by a receive push that arrives while `rx_count` is at least `rx_afull_thr`.
- R5: Bit 11 is set only by a transmit pop that occurs while `tx_count` is at most `tx_aempty_thr`.
- R6: A receive push while `rx_full` is high sets bit 4 (overflow) and does not set bit 8, because the byte is dropped.
- R7: `irq` is the OR of status AND NOT mask, taken from registered values. It changes one cycle after status or mask changes.
- R8: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: After reset, status is all zero, the mask reads 0xFBF (every implemented bit set), and `irq` is 0.
- R10: Reads change nothing. Bit 6 reads zero in both registers and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rd_empty | input | 1 | Receive-data FIFO read while empty |
| ev_wr_full | input | 1 | Write FIFO written while full |
| ev_frame_err | input | 1 | No stop bit on the received byte |
| ev_parity_err | input | 1 | Parity mismatch on the received byte |
| ev_proto_rd | input | 1 | Illegal receive read in protocol mode |
| rx_push | input | 1 | Received byte offered to the receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_afull_thr | input | CNT_W | Receive almost-full threshold |
| tx_pop | input | 1 | Transmit FIFO pop |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_aempty_thr | input | CNT_W | Transmit almost-empty threshold |
| wf_pop | input | 1 | Write FIFO pop |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
An event or write presented in a cycle shows in `reg_rdata` after the next rising edge. `irq` follows one edge after that, because it is registered from the registered status and mask. The bench drives inputs on the falling edge and steps its reference model at each rising edge. It computes the expected `irq` from the model state held before that edge, and compares all outputs at the following falling edge. Threshold boundaries, overflow, set-versus-clear collisions and masked recording are each driven directly, and the same model then checks a long seeded random run.

// File: rtl/uart_evt_irq_pkg.sv
// Shared constants for the UART event interrupt controller.
package uart_evt_irq_pkg;
    localparam int NUM_EVT      = 12;
    localparam int B_RD_EMPTY   = 0;
    localparam int B_WR_FULL    = 1;
    localparam int B_FRAME      = 2;
    localparam int B_PARITY     = 3;
    localparam int B_RX_OVF     = 4;
    localparam int B_RX_AFULL   = 5;
    localparam int B_RSVD       = 6;
    localparam int B_TX_POP     = 7;
    localparam int B_RX_PUSH    = 8;
    localparam int B_WF_POP     = 9;
    localparam int B_PROTO_RD   = 10;
    localparam int B_TX_AEMPTY  = 11;
    localparam logic [NUM_EVT-1:0] VALID_BITS = 12'hFBF;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/uart_evt_detect.sv
// Event detector: maps strobes and FIFO levels to a one-cycle event vector.
// Assumes the strobes are single-cycle and synchronous to clk. The counts are
// the occupancy before the push or pop in the same cycle.
module uart_evt_detect
    import uart_evt_irq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_rd_empty,
    input  logic               ev_wr_full,
    input  logic               ev_frame_err,
    input  logic               ev_parity_err,
    input  logic               ev_proto_rd,
    input  logic               rx_push,
    input  logic               rx_full,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_afull_thr,
    input  logic               tx_pop,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [CNT_W-1:0]   tx_aempty_thr,
    input  logic               wf_pop,
    output logic [NUM_EVT-1:0] evt
);

    // Build the event vector; the threshold events are qualified by push/pop.
    always_comb begin
        evt               = '0;
        evt[B_RD_EMPTY]   = ev_rd_empty;
        evt[B_WR_FULL]    = ev_wr_full;
        evt[B_FRAME]      = ev_frame_err;
        evt[B_PARITY]     = ev_parity_err;
        evt[B_RX_OVF]     = rx_push && rx_full;
        evt[B_RX_AFULL]   = rx_push && (rx_count >= rx_afull_thr);
        evt[B_TX_POP]     = tx_pop;
        evt[B_RX_PUSH]    = rx_push && !rx_full;
        evt[B_WF_POP]     = wf_pop;
        evt[B_PROTO_RD]   = ev_proto_rd;
        evt[B_TX_AEMPTY]  = tx_pop && (tx_count <= tx_aempty_thr);
    end

    AST_OVF_NOT_PUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |-> !evt[B_RX_PUSH]);                         // R6
    AST_AFULL_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_push |-> !evt[B_RX_AFULL]);                                  // R4
    AST_AEMPTY_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pop |-> !evt[B_TX_AEMPTY]);                                  // R5
endmodule

// File: rtl/uart_evt_status.sv
// Sticky status register with write-one-to-clear.
// Assumes that set and clear may hit the same bit in one cycle; set wins.
// Reserved positions (outside VALID) are held at zero.
module uart_evt_status #(
    parameter int               W     = 12,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status_q
);

    // Per-bit sticky storage generated over the width.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_impl
            // Clear on a written one, then let a same-cycle set override it.
            always_ff @(posedge clk) begin
                if (!rst_n)      status_q[i] <= 1'b0;
                else if (set[i]) status_q[i] <= 1'b1;
                else if (clr[i]) status_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign status_q[i] = 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        |set |=> ((status_q & $past(set & VALID)) == $past(set & VALID)));     // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clr == '0 |=> ((status_q & $past(status_q)) == $past(status_q)));      // R2
endmodule

// File: rtl/uart_evt_irq_out.sv
// Mask register and registered interrupt output.
// Assumes the mask resets to all implemented bits set, so every source starts
// masked. irq is taken from registered status and mask, so it lags them by one cycle.
module uart_evt_irq_out #(
    parameter int           W     = 12,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask_q,
    output logic         irq
);

    // Mask storage; reserved bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= VALID;
        else if (mask_we) mask_q <= mask_wdata & VALID;
    end

    // Registered OR of the unmasked status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & ~mask_q);
    end

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & VALID) == VALID) |=> !irq);                           // R3
    AST_NO_STATUS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq);                                        // R7
endmodule

// File: rtl/uart_evt_irq.sv
// Top of the UART event interrupt controller: event detection, sticky status,
// mask and interrupt line, plus a two-register read/write port
// (select 0 status, select 1 mask). Reads have no side effects.
module uart_evt_irq
    import uart_evt_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_rd_empty,
    input  logic               ev_wr_full,
    input  logic               ev_frame_err,
    input  logic               ev_parity_err,
    input  logic               ev_proto_rd,
    input  logic               rx_push,
    input  logic               rx_full,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_afull_thr,
    input  logic               tx_pop,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [CNT_W-1:0]   tx_aempty_thr,
    input  logic               wf_pop,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [NUM_EVT-1:0] reg_wdata,
    output logic [NUM_EVT-1:0] reg_rdata,
    output logic               irq
);

    logic [NUM_EVT-1:0] evt;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] w1c;
    logic               mask_we;

    uart_evt_detect #(.CNT_W(CNT_W)) u_detect (
        .clk(clk), .rst_n(rst_n),
        .ev_rd_empty(ev_rd_empty), .ev_wr_full(ev_wr_full),
        .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
        .ev_proto_rd(ev_proto_rd), .rx_push(rx_push), .rx_full(rx_full),
        .rx_count(rx_count), .rx_afull_thr(rx_afull_thr),
        .tx_pop(tx_pop), .tx_count(tx_count), .tx_aempty_thr(tx_aempty_thr),
        .wf_pop(wf_pop), .evt(evt)
    );

    // Decode the register writes into a clear vector and a mask strobe.
    always_comb begin
        w1c     = (reg_wr && reg_sel == SEL_STATUS) ? reg_wdata : '0;
        mask_we = reg_wr && (reg_sel == SEL_MASK);
    end

    uart_evt_status #(.W(NUM_EVT), .VALID(VALID_BITS)) u_status (
        .clk(clk), .rst_n(rst_n), .set(evt), .clr(w1c), .status_q(status_q)
    );

    uart_evt_irq_out #(.W(NUM_EVT), .VALID(VALID_BITS)) u_irq (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(reg_wdata),
        .status(status_q), .mask_q(mask_q), .irq(irq)
    );

    // Side-effect-free read multiplexer.
    assign reg_rdata = (reg_sel == SEL_MASK) ? mask_q : status_q;

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_RSVD]);                                             // R10
    AST_MASKED_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        evt[B_FRAME] |=> (status_q[B_FRAME] || irq == $past(irq)) && status_q[B_FRAME]); // R3
endmodule

// File: tb/uart_evt_irq_tb_top.sv
module uart_evt_irq_tb_top;
    localparam int DEPTH = 256;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [11:0] VALID = 12'hFBF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_rd_empty, ev_wr_full, ev_frame_err, ev_parity_err, ev_proto_rd;
    logic rx_push, rx_full, tx_pop, wf_pop;
    logic [CW-1:0] rx_count, rx_afull_thr, tx_count, tx_aempty_thr;
    logic reg_sel, reg_wr;
    logic [11:0] reg_wdata, reg_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_st, m_mk;
    logic m_irq;

    always #10 clk = ~clk;

    uart_evt_irq #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_rd_empty(ev_rd_empty), .ev_wr_full(ev_wr_full),
        .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
        .ev_proto_rd(ev_proto_rd), .rx_push(rx_push), .rx_full(rx_full),
        .rx_count(rx_count), .rx_afull_thr(rx_afull_thr),
        .tx_pop(tx_pop), .tx_count(tx_count), .tx_aempty_thr(tx_aempty_thr),
        .wf_pop(wf_pop), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Expected event vector, computed from the requirements.
    function automatic logic [11:0] exp_evt();
        logic [11:0] e = '0;
        e[0]  = ev_rd_empty;
        e[1]  = ev_wr_full;
        e[2]  = ev_frame_err;
        e[3]  = ev_parity_err;
        e[4]  = rx_push && rx_full;
        e[5]  = rx_push && (rx_count >= rx_afull_thr);
        e[7]  = tx_pop;
        e[8]  = rx_push && !rx_full;
        e[9]  = wf_pop;
        e[10] = ev_proto_rd;
        e[11] = tx_pop && (tx_count <= tx_aempty_thr);
        return e;
    endfunction

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ev_rd_empty = 0; ev_wr_full = 0; ev_frame_err = 0; ev_parity_err = 0;
        ev_proto_rd = 0; rx_push = 0; rx_full = 0; tx_pop = 0; wf_pop = 0;
        reg_wr = 0; reg_wdata = '0;
    endtask

    // One clock: step the model at the rising edge, return at the falling edge.
    task automatic cycle();
        logic [11:0] ev, clr;
        ev  = exp_evt();
        clr = (reg_wr && !reg_sel) ? reg_wdata : '0;
        @(posedge clk);
        m_irq = |(m_st & ~m_mk);
        m_st  = ((m_st & ~clr) | ev) & VALID;
        if (reg_wr && reg_sel) m_mk = reg_wdata & VALID;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic sel, input logic [11:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic wr(input logic sel, input logic [11:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        cycle();
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        reg_sel = 0;
        rx_count = 0; tx_count = 0; rx_afull_thr = 9'd10; tx_aempty_thr = 9'd3;
        m_st = '0; m_mk = VALID; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset values
        rd(0, 12'h000, "R9 status");
        rd(1, 12'hFBF, "R9 mask");
        chk({11'b0, irq}, 12'h0, "R9 irq");

        // R1 each event bit in its own position
        ev_rd_empty = 1;   cycle(); rd(0, 12'h001, "R1 bit0");
        ev_wr_full = 1;    cycle(); rd(0, 12'h003, "R1 bit1");
        ev_frame_err = 1;  cycle(); rd(0, 12'h007, "R1 bit2");
        ev_parity_err = 1; cycle(); rd(0, 12'h00F, "R1 bit3");
        tx_pop = 1; tx_count = 9'd50; cycle(); rd(0, 12'h08F, "R1 bit7");
        wf_pop = 1;        cycle(); rd(0, 12'h28F, "R1 bit9");
        ev_proto_rd = 1;   cycle(); rd(0, 12'h68F, "R1 bit10");
        rx_push = 1; rx_count = 9'd2; cycle(); rd(0, 12'h78F, "R1 bit8");

        // R2 write 0 leaves, write 1 clears
        wr(0, 12'h000); rd(0, 12'h78F, "R2 zero write");
        wr(0, 12'h00A); rd(0, 12'h785, "R2 w1c");
        wr(0, 12'hFFF); rd(0, 12'h000, "R2 clear all");

        // R4 receive almost-full boundary (threshold 10)
        rx_push = 1; rx_count = 9'd9;  cycle(); rd(0, 12'h100, "R4 below thr");
        chk({11'b0, irq}, 12'h0, "R3 fully masked irq");
        rx_count = 9'd10; cycle(); rd(0, 12'h100, "R4 no push");
        rx_push = 1; rx_count = 9'd10; cycle(); rd(0, 12'h120, "R4 at thr");
        wr(0, 12'hFFF);

        // R5 transmit almost-empty boundary (threshold 3)
        tx_pop = 1; tx_count = 9'd4; cycle(); rd(0, 12'h080, "R5 above thr");
        tx_pop = 1; tx_count = 9'd3; cycle(); rd(0, 12'h880, "R5 at thr");
        wr(0, 12'hFFF);

        // R6 overflow drops the byte
        rx_push = 1; rx_full = 1; rx_count = 9'd0; cycle();
        rd(0, 12'h010, "R6 overflow without push");
        wr(0, 12'hFFF);

        // R8 set beats clear in the same cycle
        ev_parity_err = 1; cycle();
        ev_parity_err = 1; reg_sel = 0; reg_wr = 1; reg_wdata = 12'h008; cycle();
        rd(0, 12'h008, "R8 set wins");
        wr(0, 12'hFFF);

        // R10 reserved bit ignores writes; reads have no effect
        wr(1, 12'hFFF); rd(1, 12'hFBF, "R10 mask rsvd");
        rd(0, 12'h000, "R10 status read");
        ev_frame_err = 1; cycle();
        rd(0, 12'h004, "R10 read 1"); cycle(); rd(0, 12'h004, "R10 read 2");
        wr(0, 12'hFFF);

        // R3 / R7 masked recording, then unmask and timing of irq
        ev_frame_err = 1; cycle();
        rd(0, 12'h004, "R3 recorded while masked");
        chk({11'b0, irq}, 12'h0, "R3 masked irq");
        wr(1, 12'hFFB);
        chk({11'b0, irq}, 12'h0, "R7 irq one cycle after mask");
        cycle();
        chk({11'b0, irq}, 12'h1, "R7 irq raised");
        wr(0, 12'h004);
        chk({11'b0, irq}, 12'h1, "R7 irq lags clear");
        cycle();
        chk({11'b0, irq}, 12'h0, "R7 irq dropped");

        // Seeded random run against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            ev_rd_empty   = ($urandom % 16) == 0;
            ev_wr_full    = ($urandom % 16) == 0;
            ev_frame_err  = ($urandom % 16) == 0;
            ev_parity_err = ($urandom % 16) == 0;
            ev_proto_rd   = ($urandom % 16) == 0;
            rx_push       = ($urandom % 6) == 0;
            rx_full       = ($urandom % 5) == 0;
            tx_pop        = ($urandom % 6) == 0;
            wf_pop        = ($urandom % 10) == 0;
            rx_count      = CW'($urandom % 257);
            tx_count      = CW'($urandom % 257);
            rx_afull_thr  = CW'($urandom % 257);
            tx_aempty_thr = CW'($urandom % 257);
            r = $urandom % 8;
            reg_sel   = r[0];
            reg_wr    = (r >= 5);
            reg_wdata = 12'($urandom);
            cycle();
            chk({11'b0, irq}, {11'b0, m_irq}, "R7 random irq");
            rd(0, m_st, "R1 random status");
            rd(1, m_mk, "R3 random mask");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule